// File: doc/BRIEF.md
# Local Interrupt Request and Service Tracker

This block is the per-processor half of an interrupt controller. It keeps one request bit and one in-service bit for each interrupt vector. The I/O router posts a set-request with a vector number and the block records it. At each instruction boundary where the processor has interrupts enabled, the block looks for the highest pending request. If that request's priority class is above everything already in service, the block hands the vector to the processor. In the same step it moves the bit from the request bitmap to the in-service bitmap.

Software retires the current in-service vector by writing a zero word to the end-of-interrupt register. The next enabled boundary then repeats the comparison. Software can read both bitmaps as arrays of 32-bit words.

Top module: `lirq_tracker`

## Requirements
- R1: A set-request (`set_valid` high while `set_ready` is high) sets the request bit of `set_vec` at the next clock edge.
- R2: A delivery is considered only in a cycle where `boundary` and `int_en` are both high. With `int_en` low, `boundary` delivers nothing and leaves both bitmaps unchanged.
- R3: The request chosen is the highest-numbered set request bit.
- R4: The chosen request is delivered only if no in-service bit is set, or its class (vector bits 7:4) is strictly greater than the class of the highest set in-service bit. An equal or lower class waits.
- R5: A delivery drives `irq_valid` high for exactly one cycle, starting in the cycle after the boundary, with `irq_vec` holding the vector. In the same clock edge the vector's in-service bit is set and its request bit is cleared.
- R6: A register write of 0x00000000 to offset 0xB0 clears only the highest-numbered set in-service bit. A write of any other value to that offset changes nothing.
- R7: An end-of-interrupt write while no in-service bit is set has no effect.
- R8: `set_ready` is high from the first clock edge after reset is released. A set-request for a vector whose request bit is already set leaves the bitmap as it was.
- R9: Request word k (vectors 32k..32k+31, bit n = vector 32k+n) reads at offset 0x200+0x10*k. In-service word k reads at 0x100+0x10*k, for k = 0..7. Every other offset reads zero.
- R10: If a set-request for vector v arrives in the same cycle that vector v is delivered, the request bit of v stays set after the delivery.
- R11: Reset clears both bitmaps and holds `irq_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_valid | input | 1 | Set-request from the I/O router |
| set_vec | input | 8 | Vector of the set-request |
| set_ready | output | 1 | Block can accept a set-request |
| boundary | input | 1 | Instruction-boundary strobe from the processor |
| int_en | input | 1 | Processor interrupt-enable flag |
| irq_valid | output | 1 | One-cycle interrupt delivery pulse |
| irq_vec | output | 8 | Delivered vector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |

## Verification
The hardest state to reach from the ports is one where several in-service bits are nested in different classes while requests of equal and lower class are pending. The R4 and R6 decisions only show up there. The stimulus table builds that state step by step. It delivers a class-3 vector, posts lower and equal-class requests that must wait, and then delivers a class-4 vector on top. After that, end-of-interrupt writes unwind the stack one level at a time, and each blocked request is released in turn. Directed tests then put a set-request for the vector being delivered into the same cycle as its boundary. They also nest two service levels to show that only the top one is retired.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   localparam int unsigned LIRQ_DW = 32;
   localparam int unsigned LIRQ_STRIDE_LSB = 4;
   typedef enum logic [1:0] {
      LIRQ_OP_SET = 2'd0,
      LIRQ_OP_BND = 2'd1,
      LIRQ_OP_EOI = 2'd2
   } lirq_op_e;
endpackage

// File: rtl/lirq_hi_find.sv
module lirq_hi_find #(
   parameter int unsigned N  = 256,
   parameter int unsigned WW = 32
) (
   input  logic [N-1:0]         vec,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int unsigned NW  = N / WW;
   localparam int unsigned WIW = $clog2(NW);
   localparam int unsigned BIW = $clog2(WW);

   if (NW < 2 || (1 << WIW) != NW || (1 << BIW) != WW) begin : g_bad_geom
      $error("lirq_hi_find: N/WW must be a power of two of at least 2");
   end

   logic [NW-1:0]  w_any;
   logic [WIW-1:0] w_idx;
   logic [BIW-1:0] b_idx;
   logic [WW-1:0]  w_sel;

   for (genvar g = 0; g < NW; g++) begin : g_word
      assign w_any[g] = |vec[g*WW +: WW];
   end

   always_comb begin
      w_idx = '0;
      for (int w = 0; w < NW; w++) begin
         if (w_any[w]) w_idx = WIW'(w);
      end
      w_sel = vec[w_idx*WW +: WW];
      b_idx = '0;
      for (int b = 0; b < WW; b++) begin
         if (w_sel[b]) b_idx = BIW'(b);
      end
   end

   assign any = |w_any;
   assign idx = {w_idx, b_idx};
endmodule

// File: rtl/lirq_rd_mux.sv
module lirq_rd_mux
   import lirq_pkg::*;
#(
   parameter int unsigned N        = 256,
   parameter int unsigned AW       = 12,
   parameter logic [11:0] ISR_BASE = 12'h100,
   parameter logic [11:0] IRR_BASE = 12'h200
) (
   input  logic [N-1:0]         irr,
   input  logic [N-1:0]         isr,
   input  logic [AW-1:0]        addr,
   output logic [LIRQ_DW-1:0]   rdata
);
   localparam int unsigned NW   = N / LIRQ_DW;
   localparam int unsigned WIW  = $clog2(NW);
   localparam int unsigned SPAN = LIRQ_STRIDE_LSB + WIW;

   if (SPAN >= AW || ISR_BASE[SPAN-1:0] != '0 || IRR_BASE[SPAN-1:0] != '0) begin : g_bad_base
      $error("lirq_rd_mux: bases must be aligned to the window span");
   end

   logic [N-1:0]       irr_w [NW];
   logic [N-1:0]       isr_w [NW];
   logic [WIW-1:0]     w_sel;
   logic               low_zero;
   logic               hit_irr;
   logic               hit_isr;

   for (genvar g = 0; g < NW; g++) begin : g_word
      assign irr_w[g] = irr >> (g * LIRQ_DW);
      assign isr_w[g] = isr >> (g * LIRQ_DW);
   end

   assign w_sel    = addr[LIRQ_STRIDE_LSB +: WIW];
   assign low_zero = (addr[LIRQ_STRIDE_LSB-1:0] == '0);
   assign hit_irr  = low_zero && (addr[AW-1:SPAN] == IRR_BASE[AW-1:SPAN]);
   assign hit_isr  = low_zero && (addr[AW-1:SPAN] == ISR_BASE[AW-1:SPAN]);

   always_comb begin
      rdata = '0;
      if (hit_irr)      rdata = irr_w[w_sel][LIRQ_DW-1:0];
      else if (hit_isr) rdata = isr_w[w_sel][LIRQ_DW-1:0];
   end
endmodule

// File: rtl/lirq_tracker.sv
module lirq_tracker
   import lirq_pkg::*;
#(
   parameter int unsigned NVEC     = 256,
   parameter int unsigned AW       = 12,
   parameter int unsigned CLS_LSB  = 4,
   parameter logic [11:0] EOI_OFS  = 12'h0B0,
   parameter logic [11:0] ISR_BASE = 12'h100,
   parameter logic [11:0] IRR_BASE = 12'h200
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  set_valid,
   input  logic [$clog2(NVEC)-1:0] set_vec,
   output logic                  set_ready,
   input  logic                  boundary,
   input  logic                  int_en,
   output logic                  irq_valid,
   output logic [$clog2(NVEC)-1:0] irq_vec,
   input  logic                  reg_wr,
   input  logic [AW-1:0]         reg_addr,
   input  logic [LIRQ_DW-1:0]    reg_wdata,
   output logic [LIRQ_DW-1:0]    reg_rdata
);
   localparam int unsigned VW = $clog2(NVEC);

   if (CLS_LSB >= VW || AW > 12) begin : g_bad_cfg
      $error("lirq_tracker: class field or address width out of range");
   end

   logic [NVEC-1:0] irr_q, isr_q;
   logic            ready_q;
   logic            irr_any, isr_any;
   logic [VW-1:0]   irr_top, isr_top;
   logic            fire, eoi, set_hit;
   logic [NVEC-1:0] fire_mask, eoi_mask, set_mask;

   lirq_hi_find #(.N(NVEC), .WW(LIRQ_DW)) u_irr_find (
      .vec(irr_q), .any(irr_any), .idx(irr_top));

   lirq_hi_find #(.N(NVEC), .WW(LIRQ_DW)) u_isr_find (
      .vec(isr_q), .any(isr_any), .idx(isr_top));

   lirq_rd_mux #(.N(NVEC), .AW(AW), .ISR_BASE(ISR_BASE), .IRR_BASE(IRR_BASE)) u_rd (
      .irr(irr_q), .isr(isr_q), .addr(reg_addr), .rdata(reg_rdata));

   assign fire = boundary && int_en && irr_any &&
                 (!isr_any || (irr_top[VW-1:CLS_LSB] > isr_top[VW-1:CLS_LSB]));
   assign eoi  = reg_wr && (reg_addr == EOI_OFS[AW-1:0]) && (reg_wdata == '0) && isr_any;
   assign set_hit = set_valid && ready_q;

   assign fire_mask = fire    ? (NVEC'(1) << irr_top) : '0;
   assign eoi_mask  = eoi     ? (NVEC'(1) << isr_top) : '0;
   assign set_mask  = set_hit ? (NVEC'(1) << set_vec) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q     <= '0;
         isr_q     <= '0;
         ready_q   <= 1'b0;
         irq_valid <= 1'b0;
         irq_vec   <= '0;
      end else begin
         irr_q     <= (irr_q & ~fire_mask) | set_mask;
         isr_q     <= (isr_q & ~eoi_mask) | fire_mask;
         ready_q   <= 1'b1;
         irq_valid <= fire;
         if (fire) irq_vec <= irr_top;
      end
   end

   assign set_ready = ready_q;
endmodule

// File: rtl/lirq_tracker_chk.sv
module lirq_tracker_chk #(
   parameter int unsigned NVEC    = 256,
   parameter int unsigned AW      = 12,
   parameter int unsigned CLS_LSB = 4,
   parameter logic [11:0] EOI_OFS = 12'h0B0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    set_ready,
   input logic                    boundary,
   input logic                    int_en,
   input logic                    irq_valid,
   input logic [$clog2(NVEC)-1:0] irq_vec,
   input logic                    reg_wr,
   input logic [AW-1:0]           reg_addr,
   input logic [31:0]             reg_wdata,
   input logic [NVEC-1:0]         isr_q
);
   localparam int unsigned VW = $clog2(NVEC);
   logic [VW-CLS_LSB-1:0] top_cls;
   logic                  eoi_wr;

   always_comb begin
      top_cls = '0;
      for (int i = 0; i < NVEC; i++) begin
         if (isr_q[i]) top_cls = (VW-CLS_LSB)'(i >> CLS_LSB);
      end
   end

   assign eoi_wr = reg_wr && (reg_addr == EOI_OFS[AW-1:0]) && (reg_wdata == 32'h0);

   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> $past(boundary && int_en));

   p_marks_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> isr_q[irq_vec]);

   p_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && $past(isr_q != '0)) |-> (irq_vec[VW-1:CLS_LSB] > $past(top_cls)));

   p_eoi_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && isr_q != '0) |=>
         ($countones(isr_q) + 1 == $past($countones(isr_q)) + (irq_valid ? 1 : 0)));

   p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> set_ready);

   p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |=> !irq_valid || $past(boundary));
endmodule

bind lirq_tracker lirq_tracker_chk #(
   .NVEC(NVEC), .AW(AW), .CLS_LSB(CLS_LSB), .EOI_OFS(EOI_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .set_ready(set_ready), .boundary(boundary),
   .int_en(int_en), .irq_valid(irq_valid), .irq_vec(irq_vec), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .isr_q(isr_q)
);

// File: tb/lirq_tracker_tb_top.sv
`timescale 1ns/1ps
module lirq_tracker_tb_top;
   import lirq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_valid = 1'b0;
   logic [7:0]  set_vec = '0;
   logic        set_ready;
   logic        boundary = 1'b0;
   logic        int_en = 1'b0;
   logic        irq_valid;
   logic [7:0]  irq_vec;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lirq_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vec(set_vec),
      .set_ready(set_ready), .boundary(boundary), .int_en(int_en),
      .irq_valid(irq_valid), .irq_vec(irq_vec), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   // op[18:17], value[16:9], expect delivery[8], expected vector[7:0]
   localparam int NT = 16;
   localparam logic [18:0] TBL [NT] = '{
      {LIRQ_OP_SET, 8'h31, 1'b0, 8'h00},
      {LIRQ_OP_BND, 8'h00, 1'b1, 8'h31},
      {LIRQ_OP_SET, 8'h25, 1'b0, 8'h00},
      {LIRQ_OP_BND, 8'h00, 1'b0, 8'h00},
      {LIRQ_OP_SET, 8'h3A, 1'b0, 8'h00},
      {LIRQ_OP_BND, 8'h00, 1'b0, 8'h00},
      {LIRQ_OP_SET, 8'h41, 1'b0, 8'h00},
      {LIRQ_OP_BND, 8'h00, 1'b1, 8'h41},
      {LIRQ_OP_EOI, 8'h00, 1'b0, 8'h00},
      {LIRQ_OP_BND, 8'h00, 1'b0, 8'h00},
      {LIRQ_OP_EOI, 8'h00, 1'b0, 8'h00},
      {LIRQ_OP_BND, 8'h00, 1'b1, 8'h3A},
      {LIRQ_OP_EOI, 8'h00, 1'b0, 8'h00},
      {LIRQ_OP_BND, 8'h00, 1'b1, 8'h25},
      {LIRQ_OP_EOI, 8'h00, 1'b0, 8'h00},
      {LIRQ_OP_BND, 8'h00, 1'b0, 8'h00}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one cycle, then look at the delivery output one cycle later
   task automatic step(input lirq_op_e op, input logic [7:0] v, input logic en,
                       input logic [31:0] wdata);
      @(negedge clk);
      case (op)
         LIRQ_OP_SET: begin set_valid = 1'b1; set_vec = v; end
         LIRQ_OP_BND: begin boundary = 1'b1; int_en = en; end
         default: begin reg_wr = 1'b1; reg_addr = 12'h0B0; reg_wdata = wdata; end
      endcase
      @(negedge clk);
      set_valid = 1'b0; boundary = 1'b0; reg_wr = 1'b0; int_en = 1'b0;
   endtask

   task automatic deliver_chk(input string req, input logic ev, input logic [7:0] evec);
      check(req, {31'd0, irq_valid}, {31'd0, ev});
      if (ev) check(req, {24'd0, irq_vec}, {24'd0, evec});
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(negedge clk);
      check("R11 irq idle in reset", {31'd0, irq_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 ready after reset", {31'd0, set_ready}, 32'd1);
      for (int k = 0; k < 8; k++) begin
         rd(12'(12'h200 + 16*k), d); check("R11 request word clear", d, 32'd0);
         rd(12'(12'h100 + 16*k), d); check("R11 service word clear", d, 32'd0);
      end

      // table walk: R1 R3 R4 R5 R6
      for (int i = 0; i < NT; i++) begin
         step(lirq_op_e'(TBL[i][18:17]), TBL[i][16:9], 1'b1, 32'd0);
         deliver_chk("R3/R4/R5 table step", TBL[i][8], TBL[i][7:0]);
      end

      // R2: disabled boundary, R1/R9 readback, R8 duplicate absorbed
      step(LIRQ_OP_SET, 8'h50, 1'b0, 0);
      step(LIRQ_OP_BND, 8'h00, 1'b0, 0);
      deliver_chk("R2 disabled boundary", 1'b0, 8'h00);
      rd(12'h220, d); check("R1 R9 request word 2", d, 32'h0001_0000);
      step(LIRQ_OP_SET, 8'h50, 1'b0, 0);
      rd(12'h220, d); check("R8 duplicate set", d, 32'h0001_0000);
      rd(12'h224, d); check("R9 unaligned offset", d, 32'd0);
      step(LIRQ_OP_BND, 8'h00, 1'b1, 0);
      deliver_chk("R5 delivery 0x50", 1'b1, 8'h50);
      rd(12'h220, d); check("R5 request cleared", d, 32'd0);
      rd(12'h120, d); check("R5 service set", d, 32'h0001_0000);
      step(LIRQ_OP_EOI, 8'h00, 1'b0, 32'h1);
      rd(12'h120, d); check("R6 nonzero eoi ignored", d, 32'h0001_0000);
      step(LIRQ_OP_EOI, 8'h00, 1'b0, 32'h0);
      rd(12'h120, d); check("R6 eoi retires", d, 32'd0);

      // R6: nested service, only top retired; R7 empty eoi
      step(LIRQ_OP_SET, 8'h70, 1'b0, 0);
      step(LIRQ_OP_BND, 8'h00, 1'b1, 0);
      step(LIRQ_OP_SET, 8'h90, 1'b0, 0);
      step(LIRQ_OP_BND, 8'h00, 1'b1, 0);
      deliver_chk("R4 higher class nests", 1'b1, 8'h90);
      step(LIRQ_OP_EOI, 8'h00, 1'b0, 32'h0);
      rd(12'h140, d); check("R6 top retired", d, 32'd0);
      rd(12'h130, d); check("R6 lower kept", d, 32'h0001_0000);
      step(LIRQ_OP_EOI, 8'h00, 1'b0, 32'h0);
      rd(12'h130, d); check("R6 second retire", d, 32'd0);
      step(LIRQ_OP_EOI, 8'h00, 1'b0, 32'h0);
      for (int k = 0; k < 8; k++) begin
         rd(12'(12'h100 + 16*k), d); check("R7 empty eoi no effect", d, 32'd0);
      end

      // vectors 255 and 0
      step(LIRQ_OP_SET, 8'hFF, 1'b0, 0);
      step(LIRQ_OP_BND, 8'h00, 1'b1, 0);
      deliver_chk("R3 vector 255", 1'b1, 8'hFF);
      step(LIRQ_OP_SET, 8'h00, 1'b0, 0);
      step(LIRQ_OP_BND, 8'h00, 1'b1, 0);
      deliver_chk("R4 class 0 blocked", 1'b0, 8'h00);
      step(LIRQ_OP_EOI, 8'h00, 1'b0, 32'h0);
      step(LIRQ_OP_BND, 8'h00, 1'b1, 0);
      deliver_chk("R4 vector 0 when idle", 1'b1, 8'h00);
      step(LIRQ_OP_EOI, 8'h00, 1'b0, 32'h0);

      // R10: set and delivery of the same vector together
      step(LIRQ_OP_SET, 8'h80, 1'b0, 0);
      @(negedge clk);
      set_valid = 1'b1; set_vec = 8'h80; boundary = 1'b1; int_en = 1'b1;
      @(negedge clk);
      set_valid = 1'b0; boundary = 1'b0; int_en = 1'b0;
      deliver_chk("R10 delivery with set", 1'b1, 8'h80);
      rd(12'h240, d); check("R10 request kept", d, 32'h0000_0001);
      step(LIRQ_OP_EOI, 8'h00, 1'b0, 32'h0);
      step(LIRQ_OP_BND, 8'h00, 1'b1, 0);
      deliver_chk("R10 redelivery", 1'b1, 8'h80);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule